// File: doc/BRIEF.md
# Eight-Channel Counting Input Filter with Hysteresis

This block cleans up eight digital input levels coming from line comparators. Each channel owns a small saturating up/down counter. The counter climbs while its effective input is high and descends while it is low. The filtered output switches high only when the counter hits its ceiling, and low only when it hits the floor. A short glitch therefore moves the counter part of the way and leaves the output alone. The counters do not step on every clock. They advance on a strobe from a programmable clock divider, and each group of four channels has its own divider and its own filter time.

A pattern register, written through a simple load strobe, is ORed into every channel's count direction. For each group, a test enable makes the pattern the only source of direction, so the live inputs of that group no longer matter. Each channel also emits a one-cycle change pulse whenever its filtered output toggles, for use by interrupt logic nearby. The register decode that produces the filter-time codes, the test enables and the pattern writes sits outside this block.

Top module: `ioflt_bank`

## Requirements
- R1: Synchronous active-high `rst` loads every channel counter with 3, clears every filtered output and change pulse to 0, and clears the pattern register to 0.
- R2: On each divider strobe of its group, a channel's counter steps up when its effective direction is 1 and down when it is 0. Starting from reset (count 3) with a steady high input, the output rises on the 4th strobe.
- R3: The filtered output goes to 1 only on the strobe that brings the counter to 7, and to 0 only on the strobe that brings it to 0. Partial excursions leave it unchanged.
- R4: Group g (channels 4g..4g+3) uses `ft_code[2g+1:2g]` to set its strobe period: code 0 gives 2 clocks, 1 gives 128, 2 gives 512 and 3 gives 1024. After reset the strobes of group g fall on clock edges R, 2R, 3R, and so on, where R is the period. A full 0-to-7 swing therefore takes 14, 896, 3584 or 7168 clocks.
- R5: The two groups run from independent dividers, so different codes give different timing in each group.
- R6: When `test_en[g]` is 0, the effective direction of a channel is its `lvl_in` bit ORed with its pattern bit.
- R7: When `test_en[g]` is 1, the `lvl_in` bits of group g are ignored and the pattern bits alone set direction.
- R8: `flt_chg[i]` is 1 for exactly the one cycle in which `flt_q[i]` first shows a new value, and is 0 otherwise.
- R9: The pattern register loads `pat_wdata` on a clock edge where `pat_we` is 1 and holds its value when `pat_we` is 0.
- R10: Counters saturate at 0 and 7 and never wrap. After any long steady input, a reversal takes exactly 7 strobes to toggle the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_in | input | 8 | Live comparator levels, one per channel |
| pat_we | input | 1 | Load strobe for the pattern register |
| pat_wdata | input | 8 | Value loaded into the pattern register |
| ft_code | input | 4 | Filter-time code, two bits per group of four channels |
| test_en | input | 2 | Per-group test enable: the pattern replaces the live levels |
| flt_q | output | 8 | Filtered channel outputs |
| flt_chg | output | 8 | One-cycle pulse on each toggle of flt_q |

## Verification
Some properties are checked by assertions on every clock. A filtered output may change only right after a strobe of its own group. The change pulse must equal the toggle of the output and can never fire on two cycles in a row. A group in test mode with a zero pattern can never raise an output. The pattern register holds whenever it is not written. The exact filter delay for each code, the hysteresis against short reversals, the OR of the pattern into the live levels and the independence of the two groups can only be shown by the bench's timed scenarios. These scenarios count strobes from reset and compare the edge on which each output toggles against the arithmetic period.

// File: rtl/ioflt_pkg.sv
package ioflt_pkg;

    localparam int CNT_W  = 3;
    localparam int GRP_W  = 4;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        FT_SHORT = 2'd0,
        FT_MID   = 2'd1,
        FT_LONG  = 2'd2,
        FT_MAX   = 2'd3
    } ftsel_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             q;
    } flt_state_t;

    function automatic int unsigned pick_ratio(ftsel_e sel, int unsigned r0,
                                               int unsigned r1, int unsigned r2,
                                               int unsigned r3);
        case (sel)
            FT_SHORT: return r0;
            FT_MID:   return r1;
            FT_LONG:  return r2;
            default:  return r3;
        endcase
    endfunction

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ioflt_divider.sv
module ioflt_divider
    import ioflt_pkg::*;
#(
    parameter int unsigned RATIO_0 = 2,
    parameter int unsigned RATIO_1 = 128,
    parameter int unsigned RATIO_2 = 512,
    parameter int unsigned RATIO_3 = 1024,
    parameter int          DIV_W   = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  ftsel_e sel,
    output logic   tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = DIV_W'(pick_ratio(sel, RATIO_0, RATIO_1, RATIO_2, RATIO_3) - 1);
        tick = (cnt_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ioflt_patreg.sv
module ioflt_patreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pat <= '0;
        end else if (we) begin
            pat <= wdata;
        end
    end

endmodule

// File: rtl/ioflt_chan.sv
module ioflt_chan
    import ioflt_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_VAL = 3'd3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic dir,
    output logic q,
    output logic chg
);

    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;

    flt_state_t st;
    flt_state_t nxt;

    always_comb begin
        nxt = st;
        if (tick) begin
            if (dir && st.cnt != TOP) begin
                nxt.cnt = st.cnt + 1'b1;
            end else if (!dir && st.cnt != BOT) begin
                nxt.cnt = st.cnt - 1'b1;
            end
        end
        if (nxt.cnt == TOP) begin
            nxt.q = 1'b1;
        end else if (nxt.cnt == BOT) begin
            nxt.q = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '{cnt: RST_VAL, q: 1'b0};
            chg <= 1'b0;
        end else begin
            st  <= nxt;
            chg <= nxt.q ^ st.q;
        end
    end

    assign q = st.q;

endmodule

// File: rtl/ioflt_bank.sv
module ioflt_bank
    import ioflt_pkg::*;
#(
    parameter int                NCH     = 8,
    parameter int unsigned       RATIO_0 = 2,
    parameter int unsigned       RATIO_1 = 128,
    parameter int unsigned       RATIO_2 = 512,
    parameter int unsigned       RATIO_3 = 1024,
    parameter logic [CNT_W-1:0]  RST_CNT = 3'd3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCH-1:0]           lvl_in,
    input  logic                     pat_we,
    input  logic [NCH-1:0]           pat_wdata,
    input  logic [CODE_W*NCH/GRP_W-1:0] ft_code,
    input  logic [NCH/GRP_W-1:0]     test_en,
    output logic [NCH-1:0]           flt_q,
    output logic [NCH-1:0]           flt_chg
);

    localparam int          NGRP  = NCH / GRP_W;
    localparam int unsigned R_MAX = max4(RATIO_0, RATIO_1, RATIO_2, RATIO_3);
    localparam int          DIV_W = (R_MAX > 2) ? $clog2(R_MAX) : 1;

    logic [NCH-1:0]  pat_q;
    logic [NGRP-1:0] grp_tick;
    logic [NCH-1:0]  dir;

    ioflt_patreg #(.W(NCH)) u_pat (
        .clk   (clk),
        .rst   (rst),
        .we    (pat_we),
        .wdata (pat_wdata),
        .pat   (pat_q)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        ioflt_divider #(
            .RATIO_0 (RATIO_0),
            .RATIO_1 (RATIO_1),
            .RATIO_2 (RATIO_2),
            .RATIO_3 (RATIO_3),
            .DIV_W   (DIV_W)
        ) u_div (
            .clk  (clk),
            .rst  (rst),
            .sel  (ftsel_e'(ft_code[CODE_W*g +: CODE_W])),
            .tick (grp_tick[g])
        );

        always_comb begin
            if (test_en[g]) begin
                dir[GRP_W*g +: GRP_W] = pat_q[GRP_W*g +: GRP_W];
            end else begin
                dir[GRP_W*g +: GRP_W] = lvl_in[GRP_W*g +: GRP_W]
                                      | pat_q[GRP_W*g +: GRP_W];
            end
        end

        for (genvar c = 0; c < GRP_W; c++) begin : g_ch
            ioflt_chan #(.RST_VAL(RST_CNT)) u_ch (
                .clk  (clk),
                .rst  (rst),
                .tick (grp_tick[g]),
                .dir  (dir[GRP_W*g + c]),
                .q    (flt_q[GRP_W*g + c]),
                .chg  (flt_chg[GRP_W*g + c])
            );
        end
    end

endmodule

// File: rtl/ioflt_bank_chk.sv
module ioflt_bank_chk #(
    parameter int NCH  = 8,
    parameter int NGRP = 2,
    parameter int GW   = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [NGRP-1:0] test_en,
    input logic            pat_we,
    input logic [NCH-1:0]  pat,
    input logic [NGRP-1:0] tick,
    input logic [NCH-1:0]  flt_q,
    input logic [NCH-1:0]  flt_chg
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flt_q == '0 && flt_chg == '0)); // R1

    AST_CHG_MATCH: assert property (@(posedge clk) disable iff (rst)
        flt_chg == (flt_q ^ $past(flt_q))); // R8

    AST_CHG_SPACED: assert property (@(posedge clk) disable iff (rst)
        (flt_chg & $past(flt_chg)) == '0); // R8

    AST_PAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(pat_we) |-> $stable(pat)); // R9

    for (genvar g = 0; g < NGRP; g++) begin : g_a
        AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
            (flt_q[GW*g +: GW] != $past(flt_q[GW*g +: GW])) |-> $past(tick[g])); // R4

        AST_TEST_IGNORE: assert property (@(posedge clk) disable iff (rst)
            ($past(test_en[g]) && $past(pat[GW*g +: GW]) == '0)
            |-> (flt_q[GW*g +: GW] & ~$past(flt_q[GW*g +: GW])) == '0); // R7
    end

endmodule

bind ioflt_bank ioflt_bank_chk #(
    .NCH  (NCH),
    .NGRP (NGRP),
    .GW   (ioflt_pkg::GRP_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .test_en (test_en),
    .pat_we  (pat_we),
    .pat     (pat_q),
    .tick    (grp_tick),
    .flt_q   (flt_q),
    .flt_chg (flt_chg)
);

// File: tb/ioflt_bank_tb.sv
`timescale 1ns/1ps
module ioflt_bank_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] lvl = '0;
    logic       pat_we = 1'b0;
    logic [7:0] pat_wd = '0;
    logic [3:0] ftc = '0;
    logic [1:0] ten = '0;
    logic [7:0] q;
    logic [7:0] chg;

    int total = 0;
    int bad   = 0;
    int at    = 0;
    logic [7:0] acc;

    always #5 clk = ~clk;

    ioflt_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .lvl_in    (lvl),
        .pat_we    (pat_we),
        .pat_wdata (pat_wd),
        .ft_code   (ftc),
        .test_en   (ten),
        .flt_q     (q),
        .flt_chg   (chg)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at edge %0d: actual=%02h expected=%02h", req, at, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        at  = 0;
    endtask

    task automatic go_to(input int n);
        while (at < n) begin
            @(negedge clk);
            at++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Scenario A: lower code 0 (R=2), upper code 1 (R=128), all inputs high
        ftc = 4'b01_00; ten = 2'b00; lvl = 8'hFF;
        @(negedge clk);
        do_reset();
        chk("R1 q after reset", q, 8'h00);
        chk("R1 chg after reset", chg, 8'h00);
        go_to(7);    chk("R2 lower before 4th strobe", q, 8'h00);
        go_to(8);    chk("R2 lower rises on 4th strobe", q, 8'h0F);
                     chk("R8 pulse with lower rise", chg, 8'h0F);
        go_to(9);    chk("R8 pulse lasts one cycle", chg, 8'h00);
        go_to(511);  chk("R4 upper code1 before edge 512", q, 8'h0F);
        go_to(512);  chk("R4 upper code1 rises at 512", q, 8'hFF);
                     chk("R8 pulse with upper rise", chg, 8'hF0);
        go_to(1024); chk("R10 saturated outputs stay high", q, 8'hFF);
        lvl = 8'h00;
        go_to(1037); chk("R10 lower before 7th down strobe", q, 8'hFF);
        go_to(1038); chk("R10 lower falls after exactly 7 strobes", q, 8'hF0);
        go_to(1919); chk("R2 upper before 7th down strobe", q, 8'hF0);
        go_to(1920); chk("R2 upper falls at 7*128", q, 8'h00);

        // Scenario C: hysteresis against partial reversals
        ftc = 4'b00_00; lvl = 8'hFF;
        do_reset();
        go_to(20); chk("R3 outputs high", q, 8'hFF);
        lvl = 8'h00;
        acc = '0;
        while (at < 26) begin go_to(at + 1); acc |= chg; end
        lvl = 8'hFF;
        while (at < 40) begin go_to(at + 1); acc |= chg; end
        chk("R3 short low burst no toggle", acc, 8'h00);
        chk("R3 output stays high", q, 8'hFF);
        lvl = 8'h00;
        go_to(52); chk("R3 still high at count 1", q, 8'hFF);
        go_to(54); chk("R3 falls at count 0", q, 8'h00);

        // Scenario D: pattern ORed with low live inputs
        ftc = 4'b00_00; lvl = 8'h00;
        do_reset();
        pat_we = 1'b1; pat_wd = 8'h05;
        go_to(1);
        pat_we = 1'b0; pat_wd = 8'hFF;
        go_to(7);  chk("R6 pattern before 4th strobe", q, 8'h00);
        go_to(8);  chk("R6 pattern bits drive direction", q, 8'h05);
        go_to(30); chk("R9 pattern held with we low", q, 8'h05);

        // Scenario E: lower group in test mode, pattern cleared by reset
        ftc = 4'b00_00; ten = 2'b01; lvl = 8'hFF;
        do_reset();
        go_to(8);  chk("R7 R1 lower ignores live inputs", q, 8'hF0);
        pat_we = 1'b1; pat_wd = 8'h02;
        go_to(9);
        pat_we = 1'b0;
        go_to(21); chk("R7 pattern channel before full swing", q, 8'hF0);
        go_to(22); chk("R7 pattern alone drives test group", q, 8'hF2);
        ten = 2'b00;

        // Scenario F: lower code 3, upper code 2
        ftc = 4'b10_11; lvl = 8'hFF;
        do_reset();
        go_to(2047); chk("R5 upper code2 before 2048", q, 8'h00);
        go_to(2048); chk("R5 upper code2 rises at 2048", q, 8'hF0);
        go_to(4095); chk("R4 lower code3 before 4096", q, 8'hF0);
        go_to(4096); chk("R4 lower code3 rises at 4096", q, 8'hFF);

        // Scenario G: mixed per-channel levels
        ftc = 4'b00_00; lvl = 8'h3C;
        do_reset();
        go_to(8); chk("R2 mixed levels", q, 8'h3C);
                  chk("R8 mixed pulse", chg, 8'h3C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule